// File: doc/BRIEF.md
# Toggle-bit completion poller

This block runs on the host side of a flash device. It works out whether a program or erase operation inside the device has finished by reading the device status byte over and over. A caller pulses `start_i` with the address to poll. The block then drives a read port, one request at a time, and compares the toggle bit between two reads in a row. When the toggle bit holds still, the operation is over. If it keeps changing after the device raises its time-limit bit, the operation has failed.

At the end the block raises `done_o` for one cycle and presents a pass/fail flag in that same cycle. On a failure it also pulses `rst_cmd_o`, which tells the surrounding logic to send the device its reset command. A pair-count limit ends the run with a failure if the status never settles, so a dead device cannot hang the poller. The bus timing and the command writes that begin the operation belong to other blocks.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_req_o` and `rst_cmd_o` are all 0.
- R2: A start taken while idle latches `addr_i`. Every read of that run presents the latched value on `rd_addr_o`, even if `addr_i` changes during the run.
- R3: Each read request is a one-cycle pulse on `rd_req_o`. No new request is issued until `rd_valid_i` has answered the previous one.
- R4: Reads come in pairs. If bit 6 of `rd_data_i` is equal in both reads of a pair, the run ends with pass (`pass_o`=1 while `done_o`=1).
- R5: If bit 6 differs within a pair and bit 5 of the second read is 0, a fresh pair is read. Bit 5 of the first read of a pair has no effect.
- R6: If bit 6 differs and bit 5 of the second read is 1, exactly one more pair is read. If that pair shows equal bit 6 values, the run ends with pass.
- R7: If bit 6 still differs in the pair that follows a bit-5=1 read, the run ends with fail and `rst_cmd_o` pulses in the `done_o` cycle.
- R8: When the pair that ends with a toggle is pair number `MAX_POLLS`, the run ends with fail and `rst_cmd_o` pulses. `rst_cmd_o` is never high on a pass.
- R9: `busy_o` is high from the cycle after an accepted start up to and including the single `done_o` cycle. It is low in the cycle after that.
- R10: A start pulse while `busy_o` is high is ignored. It changes neither the address nor the number of reads, and it does not trigger a second run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (taken only when idle) |
| addr_i | input | ADDR_W | Address of the status byte to poll |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Latched read address |
| rd_data_i | input | DATA_W | Returned status byte |
| rd_valid_i | input | 1 | Read data strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Result flag, valid with `done_o` |
| rst_cmd_o | output | 1 | Request to issue a device reset command (on fail) |

## Verification
The assertions assume the read port answers each request exactly once, with a `rd_valid_i` pulse one or more cycles after the request, and never raises `rd_valid_i` on its own. The bench responder follows this rule for every latency it uses: it counts down from each request it sees and returns exactly one scripted byte. Start pulses are driven only between clock edges, so the assertions on the request and done pulses see clean inputs.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int LIMIT_BIT  = 5,
  parameter int MAX_POLLS  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              rst_cmd_o
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              first_q;
  logic              second_q;
  logic              late_q;
  logic              pass_q;
  logic [CNT_W-1:0]  pairs_q;

  logic              toggled;
  logic [CNT_W-1:0]  pairs_next;

  assign toggled    = first_q ^ rd_data_i[TOGGLE_BIT];
  assign pairs_next = pairs_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      first_q  <= 1'b0;
      second_q <= 1'b0;
      late_q   <= 1'b0;
      pass_q   <= 1'b0;
      pairs_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          addr_q   <= addr_i;
          second_q <= 1'b0;
          late_q   <= 1'b0;
          pass_q   <= 1'b0;
          pairs_q  <= '0;
          state_q  <= S_REQ;
        end
        S_REQ: state_q <= S_WAIT;
        S_WAIT: if (rd_valid_i) begin
          if (!second_q) begin
            first_q  <= rd_data_i[TOGGLE_BIT];
            second_q <= 1'b1;
            state_q  <= S_REQ;
          end else begin
            second_q <= 1'b0;
            pairs_q  <= pairs_next;
            if (!toggled) begin
              pass_q  <= 1'b1;
              state_q <= S_DONE;
            end else if (late_q || pairs_next == CNT_W'(MAX_POLLS)) begin
              pass_q  <= 1'b0;
              state_q <= S_DONE;
            end else begin
              late_q  <= rd_data_i[LIMIT_BIT];
              state_q <= S_REQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q == S_REQ);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign pass_o    = pass_q;
  assign rst_cmd_o = done_o && !pass_q;

  a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  a_r3_req_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> busy_o);
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  a_r8_rst_only_fail: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_o |-> (done_o && !pass_o));
  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

endmodule

// File: tb/tb_toggle_poll_ctrl.sv
module tb_toggle_poll_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int MAXP   = 4;
  localparam int NV     = 8;

  localparam logic [63:0] V_SEQ [NV] = '{
    64'h0000_0000_0000_4040,  // R4 equal pair
    64'h0000_0000_4040_4000,  // R5 toggle, bit5=0, then equal
    64'h0000_0000_2020_6000,  // R6 bit5=1, recheck equal
    64'h0000_0000_6020_6000,  // R7 bit5=1, recheck toggles
    64'h0000_4040_4000_4000,  // R5 two toggling pairs
    64'h0000_6060_6000_4000,  // R6 bit5 rises on pair 2
    64'h0000_0000_0000_0060,  // R5 bit5 in first read ignored
    64'h4000_4000_4000_4000   // R8 limit reached
  };
  localparam bit V_PASS [NV] = '{1, 1, 1, 0, 1, 1, 1, 0};
  localparam int V_READS [NV] = '{2, 4, 4, 4, 6, 6, 4, 8};

  logic clk = 0, rst_n = 0, start = 0, rd_valid = 0;
  logic [ADDR_W-1:0] addr = '0, rd_addr, exp_addr = '0;
  logic [DATA_W-1:0] rd_data = '0;
  logic rd_req, busy, done, pass, rst_cmd;

  int checks = 0, errors = 0, cycles = 0;
  int lat = 1, cnt = 0, served = 0, base = 0;
  logic [63:0] cur_seq = '0;

  toggle_poll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .rd_valid_i(rd_valid), .busy_o(busy), .done_o(done), .pass_o(pass),
    .rst_cmd_o(rst_cmd));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      checks++;
      if (rd_addr != exp_addr) begin
        errors++;
        $display("FAIL R2 read addr %h expected %h", rd_addr, exp_addr);
      end
      checks++;
      if (cnt != 0) begin
        errors++;
        $display("FAIL R3 request while outstanding: cnt %0d expected 0", cnt);
      end
      cnt <= lat;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        rd_valid <= 1'b1;
        rd_data  <= cur_seq[8*(served-base) +: 8];
        served   <= served + 1;
      end
    end
  end

  task automatic summary_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles %0d expected < 100000", cycles);
      summary_end();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] seq, input bit exp_pass, input int exp_reads,
                     input int l, input bit poke_busy);
    int waited = 0;
    int dones = 0;
    @(negedge clk);
    cur_seq = seq; lat = l; base = served;
    exp_addr = ADDR_W'($urandom); addr = exp_addr; start = 1;
    @(negedge clk);
    start = 0; addr = ~exp_addr;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    while (!done && waited < 500) begin
      if (poke_busy && waited == 3) begin
        start = 1; addr = exp_addr ^ 24'h5a5a5a;
      end else start = 0;
      @(negedge clk);
      waited++;
      if (!done) check(busy == 1'b1, "R9 busy held", busy, 1);
    end
    start = 0;
    check(done == 1'b1, "R9 done seen", done, 1);
    check(pass == exp_pass, "R4/R6/R7/R8 pass flag", pass, exp_pass);
    check(rst_cmd == !exp_pass, "R7/R8 reset command", rst_cmd, !exp_pass);
    check(served - base == exp_reads, "R5/R6 read count", served - base, exp_reads);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 one-cycle done, idle after", {busy, done}, 0);
    repeat (4) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(dones == 0 && busy == 1'b0, "R10 no second run", dones, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_req && !rst_cmd, "R1 reset state",
          {busy, done, rd_req, rst_cmd}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !rd_req, "R1 idle after reset", {busy, done, rd_req}, 0);
    for (int i = 0; i < NV; i++) begin
      run(V_SEQ[i], V_PASS[i], V_READS[i], 1 + (i % 3), 1'b0);
    end
    // R10: start while busy, slow responder
    run(64'h0000_0000_4040_4000, 1'b1, 4, 3, 1'b1);
    // R7: fail path with long latency
    run(64'h0000_0000_6020_6000, 1'b0, 4, 4, 1'b1);
    summary_end();
  end
endmodule